// File: doc/BRIEF.md
# 16-bit Instruction Field and Immediate Decoder

This block is purely combinational. It takes one 16-bit instruction word and produces everything a small register-file datapath needs for that word in the same cycle:
- the two read-register indices and the write-register index;
- the register write enable;
- the memory read and write strobes;
- the 16-bit immediate, with its format chosen by the instruction class;
- the ALU operation code;
- the selects that choose where each ALU operand comes from.

The register file, the ALU, the program counter and all sequencing sit outside this block.

The three lowest bits choose one of eight instruction classes. Class 111 is split further by bits [11:9], except that bit 15 set in class 111 always means a high-merge operation. Every signed immediate takes its sign from bit 15. The long branch offset also picks up two bits from the place where the other classes keep a register field.

Top module: `insn_decode`

## Requirements
- R1: The a-select is always ir[8:6]. The write select is ir[5:3] unless R7 applies. In class 000 (register ALU) the opcode is ir[15:12].
- R2: The b-select is ir[5:3] when ir[2] is 1 and ir[11:9] when ir[2] is 0.
- R3: Classes 001 (add immediate), 011 (load) and 101 (store), and class 111 with bit 15 set (high merge), use a 7-bit signed immediate: ir[15] copied into bits [15:6], with ir[14:9] in bits [5:0].
- R4: Class 010 (move immediate) uses a 10-bit signed immediate: ir[15] copied into bits [15:9], with ir[14:6] in bits [8:0]. Its first ALU operand is the constant zero.
- R5: Class 100 (conditional branch) uses a 9-bit signed immediate: ir[15] copied into bits [15:8], with ir[13:6] in bits [7:0]. Bit 14 is not part of this immediate.
- R6: Class 110 (immediate branch) uses a 12-bit signed immediate: ir[15] copied into bits [15:11], ir[5:4] in bits [10:9], and ir[14:6] in bits [8:0].
- R7: A linking branch writes register 7 with the write enable set. A linking branch is class 110, or class 111 with bit 15 clear and ir[11:9]=000, in either case with ir[3]=1.
- R8: The ALU opcode is as follows. Class 000: ir[15:12]. High merge: 1111. Shifts (class 111, bit 15 clear, ir[11:9]=11x): {2'b10, ir[13:12]}. Every other word: 0100 (add).
- R9: The write enable is set for:
  - classes 000, 001, 010 and 011;
  - high merge;
  - ir[11:9]=100 and shifts in class 111;
  - linking branches.

  It is clear for every other word.
- R10: The memory read strobe is set only for class 011. The memory write strobe is set only for class 101.
- R11: In class 111 with bit 15 clear, ir[11:9]=100 or 101 produces the immediate {10'b0, ir[14:12], ir[8:6]}.
- R12: A shift produces an immediate of 1 when ir[9]=0 and 4 when ir[9]=1. The ALU second operand is that immediate.
- R13: Class 111 with bit 15 clear and ir[11:9] equal to 001, 010 or 011 is a no-operation. It has no write enable, no memory strobe and no immediate operand.
- R14: Operand selects are as follows.
  - First operand, xSrc: 0 = register a, 1 = program counter, 2 = zero. Classes 100 and 110 give 1. Class 010 gives 2. All other words give 0.
  - Second operand, yIsImm: 1 = immediate. It is 1 for every class except 000, and except class 111 with bit 15 clear and ir[11:9] in 000..011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ir | input | 16 | Instruction word |
| aSel | output | 3 | First read-register index |
| bSel | output | 3 | Second read-register index |
| wSel | output | 3 | Write-register index |
| wrEn | output | 1 | Register write enable |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| imm | output | 16 | Decoded immediate |
| aluOp | output | 4 | ALU operation code |
| xSrc | output | 2 | First ALU operand source |
| yIsImm | output | 1 | Second ALU operand is the immediate |

## Verification
The block holds no state, so a wrong class or format choice shows up on the ports in the same evaluation as the instruction word; nothing can linger to a later word. The signs of such a fault are easy to name:
- a misrouted format selector gives an immediate whose upper bits disagree with bit 15, or whose low bits come from the wrong field;
- a bad strobe decode asserts a write enable on a store or branch;
- a bad strobe decode asserts both memory strobes together.

The bench therefore compares every output against an independent model for every applied word. It mixes random words with words aimed at each class boundary and each sub-operation of class 111.

// File: rtl/insn_decode_pkg.sv
package insn_decode_pkg;

  localparam int unsigned InsnW = 16;
  localparam int unsigned RegIdxW = 3;
  localparam int unsigned AluOpW = 4;

  localparam logic [2:0] CLS_ALU   = 3'b000;
  localparam logic [2:0] CLS_ADDI  = 3'b001;
  localparam logic [2:0] CLS_MOVI  = 3'b010;
  localparam logic [2:0] CLS_LOAD  = 3'b011;
  localparam logic [2:0] CLS_BCOND = 3'b100;
  localparam logic [2:0] CLS_STORE = 3'b101;
  localparam logic [2:0] CLS_BIMM  = 3'b110;
  localparam logic [2:0] CLS_MISC  = 3'b111;

  localparam logic [2:0] SUB_BREG = 3'b000;
  localparam logic [2:0] SUB_LC   = 3'b100;
  localparam logic [2:0] SUB_SC   = 3'b101;
  localparam logic [2:0] SUB_SH1  = 3'b110;
  localparam logic [2:0] SUB_SH4  = 3'b111;

  localparam logic [AluOpW-1:0] ALU_ADD = 4'b0100;
  localparam logic [AluOpW-1:0] ALU_MHI = 4'b1111;
  localparam logic [1:0] ALU_SHIFT_HI = 2'b10;

  localparam logic [RegIdxW-1:0] LINK_REG = 3'd7;

  typedef enum logic [2:0] {
    IMM_SI7, IMM_SI10, IMM_SI9, IMM_SI12, IMM_U6, IMM_SHAMT
  } immFmt_e;

  typedef enum logic [1:0] {
    X_REG = 2'd0, X_PC = 2'd1, X_ZERO = 2'd2
  } xSrc_e;

  typedef struct packed {
    immFmt_e             immFmt;
    logic                bSelLow;
    logic                linkWr;
    logic                writeEn;
    logic                memRd;
    logic                memWr;
    logic [AluOpW-1:0]   aluOp;
    xSrc_e               xSrc;
    logic                yIsImm;
  } decCtrl_t;

endpackage

// File: rtl/insn_decode_ctrl.sv
module insn_decode_ctrl
  import insn_decode_pkg::*;
(
  input  logic [InsnW-1:0] ir,
  output decCtrl_t         ctrl
);

  logic unusedIr;
  assign unusedIr = ^ir[8:4];

  always_comb begin
    ctrl         = '0;
    ctrl.immFmt  = IMM_SI7;
    ctrl.aluOp   = ALU_ADD;
    ctrl.xSrc    = X_REG;
    ctrl.bSelLow = ir[2];
    case (ir[2:0])
      CLS_ALU: begin
        ctrl.writeEn = 1'b1;
        ctrl.aluOp   = ir[15:12];
      end
      CLS_ADDI: begin
        ctrl.writeEn = 1'b1;
        ctrl.yIsImm  = 1'b1;
      end
      CLS_MOVI: begin
        ctrl.writeEn = 1'b1;
        ctrl.yIsImm  = 1'b1;
        ctrl.xSrc    = X_ZERO;
        ctrl.immFmt  = IMM_SI10;
      end
      CLS_LOAD: begin
        ctrl.writeEn = 1'b1;
        ctrl.memRd   = 1'b1;
        ctrl.yIsImm  = 1'b1;
      end
      CLS_BCOND: begin
        ctrl.xSrc   = X_PC;
        ctrl.yIsImm = 1'b1;
        ctrl.immFmt = IMM_SI9;
      end
      CLS_STORE: begin
        ctrl.memWr  = 1'b1;
        ctrl.yIsImm = 1'b1;
      end
      CLS_BIMM: begin
        ctrl.linkWr  = ir[3];
        ctrl.writeEn = ir[3];
        ctrl.xSrc    = X_PC;
        ctrl.yIsImm  = 1'b1;
        ctrl.immFmt  = IMM_SI12;
      end
      default: begin
        if (ir[15]) begin
          ctrl.writeEn = 1'b1;
          ctrl.aluOp   = ALU_MHI;
          ctrl.yIsImm  = 1'b1;
        end else begin
          case (ir[11:9])
            SUB_BREG: begin
              ctrl.linkWr  = ir[3];
              ctrl.writeEn = ir[3];
            end
            SUB_LC: begin
              ctrl.writeEn = 1'b1;
              ctrl.yIsImm  = 1'b1;
              ctrl.immFmt  = IMM_U6;
            end
            SUB_SC: begin
              ctrl.yIsImm = 1'b1;
              ctrl.immFmt = IMM_U6;
            end
            SUB_SH1, SUB_SH4: begin
              ctrl.writeEn = 1'b1;
              ctrl.aluOp   = {ALU_SHIFT_HI, ir[13:12]};
              ctrl.yIsImm  = 1'b1;
              ctrl.immFmt  = IMM_SHAMT;
            end
            default: ;
          endcase
        end
      end
    endcase

    // R10
    mem_excl_chk: assert (!(ctrl.memRd && ctrl.memWr))
      else $error("both memory strobes active");
    // R9
    store_no_write_chk: assert (!ctrl.memWr || !ctrl.writeEn)
      else $error("store asserts register write");
    // R7
    link_we_chk: assert (!ctrl.linkWr || ctrl.writeEn)
      else $error("link without write enable");
  end

endmodule

// File: rtl/insn_decode_fields.sv
module insn_decode_fields
  import insn_decode_pkg::*;
(
  input  logic [InsnW-1:0]   ir,
  input  decCtrl_t           ctrl,
  output logic [RegIdxW-1:0] aSel,
  output logic [RegIdxW-1:0] bSel,
  output logic [RegIdxW-1:0] wSel,
  output logic [InsnW-1:0]   imm
);

  logic unusedBits;
  assign unusedBits = ^{ir[2:0], ctrl.writeEn, ctrl.memRd, ctrl.memWr,
                        ctrl.aluOp, ctrl.xSrc, ctrl.yIsImm};

  always_comb begin
    aSel = ir[8:6];
    bSel = ctrl.bSelLow ? ir[5:3] : ir[11:9];
    wSel = ctrl.linkWr ? LINK_REG : ir[5:3];
    case (ctrl.immFmt)
      IMM_SI10:  imm = {{7{ir[15]}}, ir[14:6]};
      IMM_SI9:   imm = {{8{ir[15]}}, ir[13:6]};
      IMM_SI12:  imm = {{5{ir[15]}}, ir[5:4], ir[14:6]};
      IMM_U6:    imm = {10'b0, ir[14:12], ir[8:6]};
      IMM_SHAMT: imm = ir[9] ? 16'd4 : 16'd1;
      default:   imm = {{10{ir[15]}}, ir[14:9]};
    endcase

    // R3
    imm_sign_chk: assert (ctrl.immFmt == IMM_U6 || ctrl.immFmt == IMM_SHAMT
                          || imm[15] == ir[15])
      else $error("signed immediate lost its sign");
    // R11
    u6_upper_zero_chk: assert (ctrl.immFmt != IMM_U6 || imm[15:6] == '0)
      else $error("unsigned immediate has high bits");
    // R7
    link_dest_chk: assert (!ctrl.linkWr || wSel == LINK_REG)
      else $error("link does not target register 7");
  end

endmodule

// File: rtl/insn_decode.sv
module insn_decode
  import insn_decode_pkg::*;
(
  input  logic [15:0] ir,
  output logic [2:0]  aSel,
  output logic [2:0]  bSel,
  output logic [2:0]  wSel,
  output logic        wrEn,
  output logic        memRd,
  output logic        memWr,
  output logic [15:0] imm,
  output logic [3:0]  aluOp,
  output logic [1:0]  xSrc,
  output logic        yIsImm
);

  decCtrl_t ctrl;

  insn_decode_ctrl uCtrl (
    .ir   (ir),
    .ctrl (ctrl)
  );

  insn_decode_fields uFields (
    .ir   (ir),
    .ctrl (ctrl),
    .aSel (aSel),
    .bSel (bSel),
    .wSel (wSel),
    .imm  (imm)
  );

  assign wrEn   = ctrl.writeEn;
  assign memRd  = ctrl.memRd;
  assign memWr  = ctrl.memWr;
  assign aluOp  = ctrl.aluOp;
  assign xSrc   = ctrl.xSrc;
  assign yIsImm = ctrl.yIsImm;

endmodule

// File: tb/insn_decode_test.sv
module insn_decode_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] ir = 16'h0000;
  logic [2:0]  aSel, bSel, wSel;
  logic        wrEn, memRd, memWr, yIsImm;
  logic [15:0] imm;
  logic [3:0]  aluOp;
  logic [1:0]  xSrc;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  insn_decode uut (
    .ir(ir), .aSel(aSel), .bSel(bSel), .wSel(wSel), .wrEn(wrEn),
    .memRd(memRd), .memWr(memWr), .imm(imm), .aluOp(aluOp),
    .xSrc(xSrc), .yIsImm(yIsImm)
  );

  function automatic logic [2:0] subOf(input logic [15:0] w);
    return w[11:9];
  endfunction

  function automatic bit isMisc(input logic [15:0] w);
    return w[2:0] == 3'b111;
  endfunction

  function automatic bit isShift(input logic [15:0] w);
    return isMisc(w) && !w[15] && w[11:10] == 2'b11;
  endfunction

  function automatic bit isLink(input logic [15:0] w);
    return w[3] && ((w[2:0] == 3'b110) ||
                    (isMisc(w) && !w[15] && subOf(w) == 3'b000));
  endfunction

  function automatic bit expYImm(input logic [15:0] w);
    if (w[2:0] == 3'b000) return 1'b0;
    if (isMisc(w) && !w[15] && !w[11]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit expWe(input logic [15:0] w);
    if (isLink(w)) return 1'b1;
    case (w[2:0])
      3'b000, 3'b001, 3'b010, 3'b011: return 1'b1;
      3'b111: return w[15] || subOf(w) == 3'b100 || isShift(w);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] expOp(input logic [15:0] w);
    if (w[2:0] == 3'b000) return w[15:12];
    if (isMisc(w) && w[15]) return 4'hF;
    if (isShift(w)) return {2'b10, w[13:12]};
    return 4'h4;
  endfunction

  function automatic logic [1:0] expX(input logic [15:0] w);
    if (w[2:0] == 3'b100 || w[2:0] == 3'b110) return 2'd1;
    if (w[2:0] == 3'b010) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [15:0] expImm(input logic [15:0] w);
    logic [15:0] s;
    s = w[15] ? 16'hFFFF : 16'h0000;
    case (w[2:0])
      3'b010: return {s[15:9], w[14:6]};
      3'b100: return {s[15:8], w[13:6]};
      3'b110: return {s[15:11], w[5:4], w[14:6]};
      3'b111: begin
        if (w[15]) return {s[15:6], w[14:9]};
        if (isShift(w)) return w[9] ? 16'd4 : 16'd1;
        return {10'd0, w[14:12], w[8:6]};
      end
      default: return {s[15:6], w[14:9]};
    endcase
  endfunction

  function automatic string immTag(input logic [15:0] w);
    case (w[2:0])
      3'b010: return "R4";
      3'b100: return "R5";
      3'b110: return "R6";
      3'b111: return w[15] ? "R3" : (isShift(w) ? "R12" : "R11");
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input int got, input int exp);
    nTests++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s %s ir=%04h actual=%0h expected=%0h",
               tag, what, ir, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk);
    ir = w;
    #2;
    chk("R1", "aSel", aSel, w[8:6]);
    chk("R2", "bSel", bSel, w[2] ? w[5:3] : w[11:9]);
    chk(isLink(w) ? "R7" : "R1", "wSel", wSel, isLink(w) ? 3'd7 : w[5:3]);
    chk(isMisc(w) && !w[15] && subOf(w) inside {3'b001, 3'b010, 3'b011}
        ? "R13" : "R9", "wrEn", wrEn, expWe(w));
    chk("R10", "memRd", memRd, w[2:0] == 3'b011);
    chk("R10", "memWr", memWr, w[2:0] == 3'b101);
    chk("R8", "aluOp", aluOp, expOp(w));
    chk("R14", "xSrc", xSrc, expX(w));
    chk("R14", "yIsImm", yIsImm, expYImm(w));
    if (expYImm(w)) chk(immTag(w), "imm", imm, expImm(w));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state word: all-zero is AND r0,r0,r0 (R1)
    apply(16'h0000);
    apply(16'hA5C0);                // R1 register ALU, opcode A
    apply(16'h8041);                // R3 add imm, most negative
    apply(16'h7FFA);                // R4 move imm max positive
    apply(16'hC014);                // R5 bit 14 set, excluded
    apply(16'h3FEC);                // R5 bit 14 clear
    apply(16'h803E);                // R6 + R7 linking, jj=11
    apply(16'h7FD6);                // R6 non-link
    apply(16'h002F);                // R7 register branch-and-link
    apply(16'h0407);                // R13 sub 010
    apply(16'h0607);                // R13 sub 011
    apply(16'h0207);                // R13 sub 001
    apply(16'h79E7);                // R11 load-control u6
    apply(16'h7BEF);                // R11 store-control u6
    apply(16'h3C47);                // R12 shift by 1
    apply(16'h2E47);                // R12 shift by 4
    apply(16'hFFFF);                // R3 high merge
    apply(16'h8003);                // R10 load
    apply(16'h7FFD);                // R10 store
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (i % 3 == 0) w[2:0] = 3'b111;
      apply(w);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule